// File: doc/BRIEF.md
# Inter-Cluster Bandwidth Lending Controller

Each cluster of a stacked multi-layer interconnect has one of these controllers. The controllers are chained into a one-way ring of message ports. At the start of a reconfiguration window a controller reads a two-bit class code for each of its local links. Idle or lightly loaded links go into a lend set. Any congested link marks the cluster as a bandwidth requester for that window.

When the lend set is not empty, the controller sends an offer round the ring. A peer that needs bandwidth, and has not yet claimed an offer in this window, answers with an accept. Any other peer passes the offer on. If the offer comes back to its sender unclaimed, it is dropped and the links stay with their owner. When an accept reaches the lender, the lender switches on its ring-enable lines for the lent links. It then sends a confirm to the acceptor. On that confirm the acceptor raises its extra-bandwidth lines and pulses a notice to its tiles. If no answer comes within a bounded wait, the lender gives up. The lender's enable lines and the acceptor's grant lines hold until the next window renegotiates them. A reset revokes all of them.

Top module: `bw_lend_ctrl`

## Requirements
- R1: After reset, ringEnable and extraGrant are all zero, needBw and tileNotify are low, and outValid is low.
- R2: Link k's class sits in linkClass[2k+1:2k]. The codes are 0 idle, 1 light, 2 normal and 3 congested. A windowStart pulse seen while idle latches the lend set, which is the links coded 0 or 1. On the same edge needBw is set if any link is coded 3, and ringEnable, extraGrant and the claim and grant history are cleared.
- R3: A non-empty lend set causes an offer message (outKind 1) with outSrc = outDst = myId and outMask = lend set. It appears on the second clock edge after the window pulse is sampled. An empty lend set sends nothing.
- R4: An incoming offer (inKind 1) from another cluster is handled one edge after it arrives. If needBw is set and nothing has been claimed this window, the reply is an accept (kind 2) with src = myId, dst = the offer's source and the offer's mask. Otherwise the offer is forwarded unchanged.
- R5: An incoming offer whose source is myId is dropped, with no output. The waiting controller goes idle, and ringEnable stays zero.
- R6: An accept (kind 2) addressed to myId while waiting for a reply sets ringEnable to the lend set two edges after it is sampled. One edge later the controller sends a confirm (kind 3) with src = myId, dst = the acceptor and the lend set as mask.
- R7: An accept or confirm that is neither addressed to nor sent by myId is forwarded unchanged one edge later. One sent by myId that comes back is dropped.
- R8: A confirm addressed to myId from the cluster whose offer was claimed sets extraGrant to its mask one edge later and pulses tileNotify for one cycle. Any other confirm, or a repeat of it, has no effect.
- R9: With no accept and no returned offer, the wait ends after TIMEOUT cycles. A later accept changes nothing and is not forwarded.
- R10: windowStart is ignored unless the controller is idle.
- R11: ringEnable changes only at a window latch or a commit. extraGrant changes only at a window latch or a valid confirm.
- R12: Ring traffic that needs a reply or a forward takes the output slot first. The controller's own offer or confirm waits for the next free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| myId | input | IDW | This cluster's ring address |
| windowStart | input | 1 | Reconfiguration window pulse |
| linkClass | input | 2*NUM_LINKS | Per-link class codes from the local monitor |
| inValid | input | 1 | Incoming ring message valid |
| inKind | input | 2 | Incoming message kind |
| inSrc | input | IDW | Incoming message source |
| inDst | input | IDW | Incoming message destination |
| inMask | input | NUM_LINKS | Incoming message link mask |
| outValid | output | 1 | Outgoing ring message valid |
| outKind | output | 2 | Outgoing message kind |
| outSrc | output | IDW | Outgoing message source |
| outDst | output | IDW | Outgoing message destination |
| outMask | output | NUM_LINKS | Outgoing message link mask |
| ringEnable | output | NUM_LINKS | Modulator and filter ring enables for lent links |
| extraGrant | output | NUM_LINKS | Borrowed links granted to the local tiles |
| tileNotify | output | 1 | One-cycle notice to the tiles of new bandwidth |
| needBw | output | 1 | This cluster is a requester in the current window |

## Verification
Different results fall due at different delays. A reply or forward appears one edge after the incoming message is sampled, and so do the grant and the tile notice. The controller's own offer is due on the second edge after the window pulse. Ring enables follow two edges after an accept, and the confirm one edge after that. The bench advances a behavioural model on each rising edge and compares every output with it on the falling edge, so each result is checked in the cycle it is due. The directed checks are placed after the matching number of falling edges.

// File: rtl/bw_lend_pkg.sv
package bw_lend_pkg;

  typedef enum logic [1:0] {
    MSG_NONE    = 2'd0,
    MSG_OFFER   = 2'd1,
    MSG_ACCEPT  = 2'd2,
    MSG_CONFIRM = 2'd3
  } msgKind_e;

  typedef enum logic [1:0] {
    LC_IDLE   = 2'd0,
    LC_LIGHT  = 2'd1,
    LC_NORMAL = 2'd2,
    LC_HEAVY  = 2'd3
  } linkClass_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFFER,
    ST_WAIT,
    ST_ACTIVATE,
    ST_CONFIRM
  } lendState_e;

  // control -> datapath
  typedef struct packed {
    logic latchWindow;
    logic emitOffer;
    logic commitRings;
    logic captureAcceptor;
    logic emitConfirm;
  } lendStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic slotBusy;
    logic acceptForMe;
    logic ownOfferBack;
    logic offerPending;
  } lendFlags_t;

endpackage

// File: rtl/bw_lend_fsm.sv
module bw_lend_fsm
  import bw_lend_pkg::*;
#(
  parameter int TIMEOUT = 24,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        windowStart,
  input  lendFlags_t  flags,
  output lendStrobe_t strobes
);

  lendState_e state, nextState;
  logic [TW-1:0] waitTimer;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (windowStart) begin
          strobes.latchWindow = 1'b1;
          if (flags.offerPending) nextState = ST_OFFER;
        end
      end
      ST_OFFER: begin
        if (!flags.slotBusy) begin
          strobes.emitOffer = 1'b1;
          nextState         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (flags.acceptForMe) begin
          strobes.captureAcceptor = 1'b1;
          nextState               = ST_ACTIVATE;
        end else if (flags.ownOfferBack) begin
          nextState = ST_IDLE;
        end else if (waitTimer == TW'(TIMEOUT - 1)) begin
          nextState = ST_IDLE;
        end
      end
      ST_ACTIVATE: begin
        strobes.commitRings = 1'b1;
        nextState           = ST_CONFIRM;
      end
      ST_CONFIRM: begin
        if (!flags.slotBusy) begin
          strobes.emitConfirm = 1'b1;
          nextState           = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waitTimer <= '0;
    end else begin
      state <= nextState;
      if (strobes.emitOffer)    waitTimer <= '0;
      else if (state == ST_WAIT) waitTimer <= waitTimer + TW'(1);
    end
  end

  // R9
  wait_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && $past(state) == ST_WAIT) |-> waitTimer == $past(waitTimer) + TW'(1));

  // R10
  window_idle_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != ST_IDLE && $past(state) != ST_CONFIRM && state == ST_OFFER) |-> $past(state) == ST_OFFER);

endmodule

// File: rtl/bw_lend_dp.sv
module bw_lend_dp
  import bw_lend_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int NUM_LINKS    = 4,
  localparam int IDW = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDW-1:0]         myId,
  input  logic [2*NUM_LINKS-1:0] linkClass,
  input  logic                   inValid,
  input  logic [1:0]             inKind,
  input  logic [IDW-1:0]         inSrc,
  input  logic [IDW-1:0]         inDst,
  input  logic [NUM_LINKS-1:0]   inMask,
  input  lendStrobe_t            strobes,
  output lendFlags_t             flags,
  output logic                   outValid,
  output logic [1:0]             outKind,
  output logic [IDW-1:0]         outSrc,
  output logic [IDW-1:0]         outDst,
  output logic [NUM_LINKS-1:0]   outMask,
  output logic [NUM_LINKS-1:0]   ringEnable,
  output logic [NUM_LINKS-1:0]   extraGrant,
  output logic                   tileNotify,
  output logic                   needBw
);

  // per-link classification
  logic [NUM_LINKS-1:0] lendable;
  logic [NUM_LINKS-1:0] congested;

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_cls
    linkClass_e code;
    assign code         = linkClass_e'(linkClass[2*k +: 2]);
    assign lendable[k]  = (code == LC_IDLE) || (code == LC_LIGHT);
    assign congested[k] = (code == LC_HEAVY);
  end

  logic [NUM_LINKS-1:0] offerMask;
  logic                 claimed, granted;
  logic [IDW-1:0]       claimedFrom, acceptorId;

  // incoming decode
  logic isOffer, isAccept, isConfirm, fromMe, toMe;
  logic claimNow, fwdMsg, confirmHit;

  always_comb begin
    isOffer    = inValid && (inKind == MSG_OFFER);
    isAccept   = inValid && (inKind == MSG_ACCEPT);
    isConfirm  = inValid && (inKind == MSG_CONFIRM);
    fromMe     = (inSrc == myId);
    toMe       = (inDst == myId);
    claimNow   = isOffer && !fromMe && needBw && !claimed;
    fwdMsg     = (isOffer && !fromMe && !claimNow) ||
                 ((isAccept || isConfirm) && !fromMe && !toMe);
    confirmHit = isConfirm && toMe && !fromMe && claimed && !granted &&
                 (inSrc == claimedFrom) && !strobes.latchWindow;

    flags.slotBusy     = claimNow || fwdMsg;
    flags.acceptForMe  = isAccept && toMe && !fromMe;
    flags.ownOfferBack = isOffer && fromMe;
    flags.offerPending = |lendable;
  end

  // output slot selection: ring traffic first
  logic                 nValid;
  logic [1:0]           nKind;
  logic [IDW-1:0]       nSrc, nDst;
  logic [NUM_LINKS-1:0] nMask;

  always_comb begin
    nValid = 1'b0;
    nKind  = MSG_NONE;
    nSrc   = myId;
    nDst   = myId;
    nMask  = '0;
    if (claimNow) begin
      nValid = 1'b1;
      nKind  = MSG_ACCEPT;
      nDst   = inSrc;
      nMask  = inMask;
    end else if (fwdMsg) begin
      nValid = 1'b1;
      nKind  = inKind;
      nSrc   = inSrc;
      nDst   = inDst;
      nMask  = inMask;
    end else if (strobes.emitOffer) begin
      nValid = 1'b1;
      nKind  = MSG_OFFER;
      nMask  = offerMask;
    end else if (strobes.emitConfirm) begin
      nValid = 1'b1;
      nKind  = MSG_CONFIRM;
      nDst   = acceptorId;
      nMask  = offerMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outKind  <= MSG_NONE;
      outSrc   <= '0;
      outDst   <= '0;
      outMask  <= '0;
    end else begin
      outValid <= nValid;
      outKind  <= nKind;
      outSrc   <= nSrc;
      outDst   <= nDst;
      outMask  <= nMask;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offerMask   <= '0;
      needBw      <= 1'b0;
      ringEnable  <= '0;
      extraGrant  <= '0;
      claimed     <= 1'b0;
      granted     <= 1'b0;
      claimedFrom <= '0;
      acceptorId  <= '0;
      tileNotify  <= 1'b0;
    end else begin
      tileNotify <= confirmHit;
      if (strobes.captureAcceptor) acceptorId <= inSrc;
      if (strobes.latchWindow) begin
        offerMask  <= lendable;
        needBw     <= |congested;
        ringEnable <= '0;
        extraGrant <= '0;
        claimed    <= 1'b0;
        granted    <= 1'b0;
      end else begin
        if (claimNow) begin
          claimed     <= 1'b1;
          claimedFrom <= inSrc;
        end
        if (strobes.commitRings) ringEnable <= offerMask;
        if (confirmHit) begin
          extraGrant <= inMask;
          granted    <= 1'b1;
        end
      end
    end
  end

  // R11
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ringEnable) |-> $past(strobes.latchWindow || strobes.commitRings));

  // R11
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(extraGrant) |-> $past(strobes.latchWindow || confirmHit));

  // R4
  accept_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == MSG_ACCEPT && outSrc == myId) |-> $past(needBw));

  // R6
  confirm_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == MSG_CONFIRM && outSrc == myId) |-> (ringEnable == offerMask && |ringEnable));

  // R8
  notify_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tileNotify |=> !tileNotify);

endmodule

// File: rtl/bw_lend_ctrl.sv
module bw_lend_ctrl
  import bw_lend_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4,
  parameter int NUM_LINKS    = 4,
  parameter int TIMEOUT      = 24,
  localparam int IDW = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [IDW-1:0]         myId,
  input  logic                   windowStart,
  input  logic [2*NUM_LINKS-1:0] linkClass,
  input  logic                   inValid,
  input  logic [1:0]             inKind,
  input  logic [IDW-1:0]         inSrc,
  input  logic [IDW-1:0]         inDst,
  input  logic [NUM_LINKS-1:0]   inMask,
  output logic                   outValid,
  output logic [1:0]             outKind,
  output logic [IDW-1:0]         outSrc,
  output logic [IDW-1:0]         outDst,
  output logic [NUM_LINKS-1:0]   outMask,
  output logic [NUM_LINKS-1:0]   ringEnable,
  output logic [NUM_LINKS-1:0]   extraGrant,
  output logic                   tileNotify,
  output logic                   needBw
);

  lendStrobe_t strobes;
  lendFlags_t  flags;

  bw_lend_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk(clk), .rstN(rstN), .windowStart(windowStart),
    .flags(flags), .strobes(strobes)
  );

  bw_lend_dp #(.NUM_CLUSTERS(NUM_CLUSTERS), .NUM_LINKS(NUM_LINKS)) u_dp (
    .clk(clk), .rstN(rstN), .myId(myId), .linkClass(linkClass),
    .inValid(inValid), .inKind(inKind), .inSrc(inSrc), .inDst(inDst),
    .inMask(inMask), .strobes(strobes), .flags(flags),
    .outValid(outValid), .outKind(outKind), .outSrc(outSrc),
    .outDst(outDst), .outMask(outMask), .ringEnable(ringEnable),
    .extraGrant(extraGrant), .tileNotify(tileNotify), .needBw(needBw)
  );

endmodule

// File: tb/tb_bw_lend_ctrl.sv
`timescale 1ns/1ps
module tb_bw_lend_ctrl;
  localparam int NC = 4, NL = 4, TO = 24, IDW = 2;
  localparam logic [IDW-1:0] ID = 2'd1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, windowStart = 1'b0, inValid = 1'b0;
  logic [2*NL-1:0] linkClass = '0;
  logic [1:0] inKind = '0;
  logic [IDW-1:0] inSrc = '0, inDst = '0;
  logic [NL-1:0] inMask = '0;
  logic outValid, tileNotify, needBw;
  logic [1:0] outKind;
  logic [IDW-1:0] outSrc, outDst;
  logic [NL-1:0] outMask, ringEnable, extraGrant;

  bw_lend_ctrl #(.NUM_CLUSTERS(NC), .NUM_LINKS(NL), .TIMEOUT(TO)) dut (
    .clk(clk), .rstN(rstN), .myId(ID), .windowStart(windowStart),
    .linkClass(linkClass), .inValid(inValid), .inKind(inKind),
    .inSrc(inSrc), .inDst(inDst), .inMask(inMask), .outValid(outValid),
    .outKind(outKind), .outSrc(outSrc), .outDst(outDst), .outMask(outMask),
    .ringEnable(ringEnable), .extraGrant(extraGrant),
    .tileNotify(tileNotify), .needBw(needBw)
  );

  int total = 0, fails = 0;
  string curReq = "R1";
  bit done = 0;

  task automatic cmp(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 offering, 2 waiting, 3 activating, 4 confirming
  int mSt = 0, mTimer = 0;
  bit [NL-1:0] mOffer = 0, mRing = 0, mGrant = 0;
  bit mNeed = 0, mNotify = 0, mClaimed = 0, mGranted = 0;
  bit [IDW-1:0] mClaimFrom = 0, mAcceptor = 0;
  bit mOV = 0; bit [1:0] mOK = 0; bit [IDW-1:0] mOS = 0, mOD = 0; bit [NL-1:0] mOM = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mTimer = 0; mOffer = 0; mRing = 0; mGrant = 0; mNeed = 0;
      mNotify = 0; mClaimed = 0; mGranted = 0; mOV = 0; mOK = 0; mOS = 0; mOD = 0; mOM = 0;
    end else begin
      bit off, acc, conf, fromMe, toMe, claim, fwd, busy, hit, latch, heavy;
      bit [NL-1:0] lend;
      int nxt;
      off = inValid && inKind == 2'd1;
      acc = inValid && inKind == 2'd2;
      conf = inValid && inKind == 2'd3;
      fromMe = (inSrc == ID);
      toMe = (inDst == ID);
      claim = off && !fromMe && mNeed && !mClaimed;
      fwd = (off && !fromMe && !claim) || ((acc || conf) && !fromMe && !toMe);
      busy = claim || fwd;
      latch = (mSt == 0) && windowStart;
      hit = conf && toMe && !fromMe && mClaimed && !mGranted && inSrc == mClaimFrom && !latch;
      lend = 0; heavy = 0;
      for (int k = 0; k < NL; k++) begin
        if (linkClass[2*k +: 2] <= 2'd1) lend[k] = 1;
        if (linkClass[2*k +: 2] == 2'd3) heavy = 1;
      end
      // output slot
      mOV = 0; mOK = 0; mOS = ID; mOD = ID; mOM = 0;
      if (claim) begin mOV = 1; mOK = 2; mOD = inSrc; mOM = inMask; end
      else if (fwd) begin mOV = 1; mOK = inKind; mOS = inSrc; mOD = inDst; mOM = inMask; end
      else if (mSt == 1) begin mOV = 1; mOK = 1; mOM = mOffer; end
      else if (mSt == 4) begin mOV = 1; mOK = 3; mOD = mAcceptor; mOM = mOffer; end
      mNotify = hit;
      nxt = mSt;
      case (mSt)
        0: if (latch && lend != 0) nxt = 1;
        1: if (!busy) begin nxt = 2; mTimer = -1; end
        2: if (acc && toMe && !fromMe) begin nxt = 3; mAcceptor = inSrc; end
           else if (off && fromMe) nxt = 0;
           else if (mTimer == TO - 1) nxt = 0;
        3: begin mRing = mOffer; nxt = 4; end
        4: if (!busy) nxt = 0;
        default: nxt = 0;
      endcase
      if (mSt == 2 || nxt == 2) mTimer++;
      if (latch) begin
        mOffer = lend; mNeed = heavy; mRing = 0; mGrant = 0; mClaimed = 0; mGranted = 0;
      end else begin
        if (claim) begin mClaimed = 1; mClaimFrom = inSrc; end
        if (hit) begin mGrant = inMask; mGranted = 1; end
      end
      mSt = nxt;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      cmp(curReq, "ringEnable", int'(ringEnable), int'(mRing));
      cmp(curReq, "extraGrant", int'(extraGrant), int'(mGrant));
      cmp(curReq, "tileNotify", int'(tileNotify), int'(mNotify));
      cmp(curReq, "needBw", int'(needBw), int'(mNeed));
      cmp(curReq, "outValid", int'(outValid), int'(mOV));
      if (mOV) begin
        cmp(curReq, "outKind", int'(outKind), int'(mOK));
        cmp(curReq, "outSrc", int'(outSrc), int'(mOS));
        cmp(curReq, "outDst", int'(outDst), int'(mOD));
        cmp(curReq, "outMask", int'(outMask), int'(mOM));
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic window(logic [2*NL-1:0] cls);
    linkClass = cls; windowStart = 1'b1;
    @(negedge clk);
    windowStart = 1'b0;
  endtask

  task automatic send(logic [1:0] k, logic [IDW-1:0] s, logic [IDW-1:0] d, logic [NL-1:0] m);
    inValid = 1'b1; inKind = k; inSrc = s; inDst = d; inMask = m;
    @(negedge clk);
    inValid = 1'b0; inKind = 2'd0;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    cmp("R1", "ringEnable", int'(ringEnable), 0);
    cmp("R1", "extraGrant", int'(extraGrant), 0);
    cmp("R1", "outValid", int'(outValid), 0);
    cmp("R1", "needBw", int'(needBw), 0);
    idle(2);

    // R2/R3: links 0 idle, 1 normal, 2 light, 3 congested
    curReq = "R2";
    window(8'b11_01_10_00);
    cmp("R2", "needBw", int'(needBw), 1);
    curReq = "R3";
    @(negedge clk);
    cmp("R3", "offerKind", int'(outKind), 1);
    cmp("R3", "offerMask", int'(outMask), 4'b0101);

    // R4 claim then forward
    curReq = "R4";
    send(2'd1, 2'd2, 2'd2, 4'b0010);
    cmp("R4", "acceptKind", int'(outKind), 2);
    cmp("R4", "acceptDst", int'(outDst), 2);
    send(2'd1, 2'd3, 2'd3, 4'b1000);
    cmp("R4", "forwardSrc", int'(outSrc), 3);

    // R7 forward foreign, drop own returning
    curReq = "R7";
    send(2'd2, 2'd2, 2'd0, 4'b0001);
    cmp("R7", "fwdKind", int'(outKind), 2);
    send(2'd3, ID, 2'd3, 4'b0001);
    cmp("R7", "dropOwn", int'(outValid), 0);

    // R10 window while waiting
    curReq = "R10";
    window(8'b10_10_10_10);
    cmp("R10", "needBwKept", int'(needBw), 1);
    idle(1);

    // R6 accept for me
    curReq = "R6";
    send(2'd2, 2'd3, ID, 4'b0101);
    @(negedge clk);
    cmp("R6", "ringEnable", int'(ringEnable), 4'b0101);
    @(negedge clk);
    cmp("R6", "confirmKind", int'(outKind), 3);
    cmp("R6", "confirmDst", int'(outDst), 3);
    idle(2);

    // R8 grant on confirm from claimed lender, repeat ignored
    curReq = "R8";
    send(2'd3, 2'd2, ID, 4'b0010);
    cmp("R8", "extraGrant", int'(extraGrant), 4'b0010);
    cmp("R8", "tileNotify", int'(tileNotify), 1);
    send(2'd3, 2'd2, ID, 4'b1111);
    cmp("R8", "repeatIgnored", int'(extraGrant), 4'b0010);
    cmp("R8", "noSecondNotify", int'(tileNotify), 0);

    // R11 hold
    curReq = "R11";
    idle(6);
    cmp("R11", "ringHeld", int'(ringEnable), 4'b0101);

    // R2 renegotiation: all normal
    curReq = "R2";
    window(8'b10_10_10_10);
    cmp("R2", "ringCleared", int'(ringEnable), 0);
    cmp("R2", "grantCleared", int'(extraGrant), 0);
    cmp("R2", "needBw", int'(needBw), 0);
    idle(2);
    curReq = "R4";
    send(2'd1, 2'd0, 2'd0, 4'b0011);
    cmp("R4", "forwardNoNeed", int'(outKind), 1);
    idle(2);

    // R8 confirm without claim ignored
    curReq = "R8";
    send(2'd3, 2'd0, ID, 4'b0011);
    cmp("R8", "unclaimedConfirm", int'(extraGrant), 0);
    idle(2);

    // R5 own offer returns
    curReq = "R5";
    window(8'b00_00_00_00);
    idle(2);
    send(2'd1, ID, ID, 4'b1111);
    cmp("R5", "dropped", int'(outValid), 0);
    send(2'd2, 2'd2, ID, 4'b1111);
    idle(3);
    cmp("R5", "ringStaysOff", int'(ringEnable), 0);

    // R9 timeout
    curReq = "R9";
    window(8'b01_10_10_10);
    idle(TO + 4);
    send(2'd2, 2'd0, ID, 4'b1000);
    cmp("R9", "lateAcceptNoOut", int'(outValid), 0);
    idle(3);
    cmp("R9", "ringOff", int'(ringEnable), 0);

    // R12 contention: foreign offer arrives while own offer is due
    curReq = "R12";
    window(8'b00_10_10_10);
    send(2'd1, 2'd3, 2'd3, 4'b0100);
    cmp("R12", "forwardFirst", int'(outSrc), 3);
    @(negedge clk);
    cmp("R12", "ownOfferNext", int'(outSrc), int'(ID));
    cmp("R12", "ownOfferKind", int'(outKind), 1);
    idle(TO + 4);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule